// File: doc/BRIEF.md
# Multi-Format Serial PCM Input Port

This block takes stereo PCM from an external source over three wires: a bit clock, a word clock and a serial data line. A 3-bit format code picks one of eight framings at once: word alignment (right-justified, left-justified or I2S), sample length (16, 18, 20 or 24 bits), which word-clock level marks the left channel, and whether the port receives the two clocks or generates them. In the two generating codes a divider on the system clock produces a 64-bit-per-frame bit clock and a matching word clock, and the port drives both out.

Every rising bit-clock edge shifts one data bit in, MSB first. When the word clock changes level, the word of the half that just ended is complete. A right channel followed by a left-channel boundary publishes the pair on `left_out`/`right_out`, together with a one-cycle `pair_valid`. Samples shorter than 24 bits are placed MSB-aligned, with zero low bits. The published pair stays unchanged while the next frame shifts in.

A half-frame state machine follows the stream. It has three states. ST_IDLE waits for the first left-channel boundary. ST_LEFT collects a left word. ST_RIGHT collects a right word. Its transitions are:
- ST_IDLE goes to ST_LEFT on a boundary into a left half.
- ST_LEFT goes to ST_RIGHT on a boundary into a right half, and latches the left word.
- ST_LEFT stays in ST_LEFT, restarting, on a second left boundary.
- ST_RIGHT goes to ST_LEFT on a left boundary, and publishes the pair.
- ST_RIGHT goes to ST_IDLE on a second right boundary, and drops the frame.

The format code is loaded only when the machine enters ST_LEFT. While the machine is in ST_IDLE, the loaded code follows the input.

Top module: `pcm_serial_rx`

## Requirements
- R1: Codes 0, 1, 2 and 3 are right-justified with 16, 18, 20 and 24 valid bits. The last bit before a word-clock change is the LSB. Word clock high marks the left channel. The result is MSB-aligned in 24 bits with zero low bits.
- R2: Code 4 is left-justified with word clock high marking left. The 24 bits sampled at the first 24 rising edges from the word-clock change onward form the word, MSB first.
- R3: Code 5 is I2S with word clock low marking left. The MSB is sampled at the second rising edge after the word-clock change, and 24 bits are taken.
- R4: Codes 6 (left-justified, high = left) and 7 (I2S, low = left) generate the clocks. The bit clock has a period of 2*HALF_DIV system cycles. There are 32 bit clocks per word-clock level. The word clock changes only together with a falling bit clock. `clk_drive_en` is 1 for codes 6 and 7 and 0 for codes 0 to 5.
- R5: Data is sampled on rising bit-clock edges only. Leading bits before a right-justified word, and trailing bits after a left-justified or I2S word, do not change the result.
- R6: `left_out`/`right_out` change only in the cycle where `pair_valid` is 1. `pair_valid` lasts one cycle. It is raised once per frame, on the first rising bit clock of the next left half.
- R7: A format code changed during a frame takes effect at the next left-channel boundary. The frame in flight is decoded with the old code.
- R8: After reset, `left_out` and `right_out` are zero and `pair_valid` is 0. No pair is reported until a complete left and right half have been received.
- R9: Halves of up to 64 bit clocks (128 per frame) are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Format code 0..7 |
| bclk_in | input | 1 | Bit clock from the source (codes 0..5) |
| wclk_in | input | 1 | Word clock from the source (codes 0..5) |
| sdata_in | input | 1 | Serial sample data |
| bclk_out | output | 1 | Generated bit clock |
| wclk_out | output | 1 | Generated word clock |
| clk_drive_en | output | 1 | 1 when the generated clocks are to be driven out |
| left_out | output | 24 | Left sample of the published pair |
| right_out | output | 24 | Right sample of the published pair |
| pair_valid | output | 1 | One-cycle strobe on a new pair |

## Verification
The assertions check on every cycle that the published pair never moves outside a `pair_valid` cycle. They also check that the strobe is one cycle wide and only follows a right half, and that the generated word clock changes only on a falling generated bit clock. Sample values cannot be checked that way. Which bits form a word in each alignment, the MSB placement of short samples, the ignored padding bits, the 64-bit frame, and the deferred effect of a format change are shown only by the bench scenarios. In those scenarios a behavioural model serialises known words and compares every cycle.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int FRAME_BITS = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } half_state_t;

    typedef enum logic [1:0] {
        AL_RJ  = 2'd0,
        AL_LJ  = 2'd1,
        AL_I2S = 2'd2
    } align_t;

    typedef struct packed {
        align_t     align;
        logic [4:0] len;
        logic       left_high;
        logic       master;
    } fmt_info_t;

    function automatic fmt_info_t decode_fmt(input logic [2:0] code);
        fmt_info_t f;
        f.master    = (code[2:1] == 2'b11);
        f.left_high = 1'b1;
        f.align     = AL_RJ;
        f.len       = 5'd24;
        case (code)
            3'd0: f.len = 5'd16;
            3'd1: f.len = 5'd18;
            3'd2: f.len = 5'd20;
            3'd3: f.len = 5'd24;
            3'd4, 3'd6: f.align = AL_LJ;
            default: begin
                f.align     = AL_I2S;
                f.left_high = 1'b0;
            end
        endcase
        return f;
    endfunction

    function automatic logic left_is_high(input logic [2:0] code);
        return !(code == 3'd5 || code == 3'd7);
    endfunction

endpackage

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen #(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_gen,
    output logic left_half
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam int HALF  = FRAME_BITS / 2;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] bit_nxt;
    logic             tick;

    assign tick    = (div_q == DIV_W'(HALF_DIV - 1));
    assign bit_nxt = (bit_q == CNT_W'(FRAME_BITS - 1)) ? '0 : bit_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            bclk_gen  <= 1'b0;
            bit_q     <= CNT_W'(FRAME_BITS - 1);
            left_half <= 1'b0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                bclk_gen <= ~bclk_gen;
                if (bclk_gen) begin
                    // falling edge: advance bit position and word clock together
                    bit_q     <= bit_nxt;
                    left_half <= (bit_nxt < CNT_W'(HALF));
                end
            end
        end
    end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int W     = 24,
    parameter int IDX_W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_rise,
    input  logic         wclk_s,
    input  logic         sdata_s,
    input  align_t       align,
    input  logic [4:0]   len,
    output logic         boundary,
    output logic [W-1:0] word
);
    logic             primed_q;
    logic             w_last_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;
    logic [W-1:0]     sh_q;
    logic             capture;
    logic [4:0]       shamt;

    assign boundary = bit_rise && primed_q && (wclk_s != w_last_q);

    always_comb begin
        if (boundary)
            idx_nxt = '0;
        else if (idx_q == {IDX_W{1'b1}})
            idx_nxt = idx_q;
        else
            idx_nxt = idx_q + 1'b1;
    end

    always_comb begin
        unique case (align)
            AL_RJ:   capture = 1'b1;
            AL_LJ:   capture = (idx_nxt < IDX_W'(W));
            AL_I2S:  capture = (idx_nxt >= IDX_W'(1)) && (idx_nxt <= IDX_W'(W));
            default: capture = 1'b0;
        endcase
    end

    // right-justified words sit in the low bits; move them to the top
    assign shamt = 5'(W) - len;
    assign word  = (align == AL_RJ) ? (sh_q << shamt) : sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            w_last_q <= 1'b0;
            idx_q    <= '0;
            sh_q     <= '0;
        end else if (bit_rise) begin
            primed_q <= 1'b1;
            w_last_q <= wclk_s;
            idx_q    <= idx_nxt;
            if (capture)
                sh_q <= {sh_q[W-2:0], sdata_s};
        end
    end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int IDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_sel,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                sdata_in,
    output logic                bclk_out,
    output logic                wclk_out,
    output logic                clk_drive_en,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);
    localparam int W = SAMPLE_W;

    half_state_t   state_q, state_d;
    logic [2:0]    code_q;
    fmt_info_t     info_act;
    logic          gen_bclk, gen_left;
    logic          gen_wclk;
    logic          bclk_src, wclk_src;
    logic          b_q;
    logic          bit_rise;
    logic          boundary;
    logic          into_left;
    logic [W-1:0]  half_word;
    logic [W-1:0]  left_hold_q;

    assign info_act = decode_fmt(code_q);

    pcm_rx_clkgen #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_gen  (gen_bclk),
        .left_half (gen_left)
    );

    assign gen_wclk     = gen_left ? info_act.left_high : ~info_act.left_high;
    assign bclk_out     = gen_bclk;
    assign wclk_out     = gen_wclk;
    assign clk_drive_en = info_act.master;

    assign bclk_src = info_act.master ? gen_bclk : bclk_in;
    assign wclk_src = info_act.master ? gen_wclk : wclk_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else        b_q <= bclk_src;
    end

    assign bit_rise = bclk_src & ~b_q;

    pcm_rx_deser #(
        .W     (W),
        .IDX_W (IDX_W)
    ) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .wclk_s   (wclk_src),
        .sdata_s  (sdata_in),
        .align    (info_act.align),
        .len      (info_act.len),
        .boundary (boundary),
        .word     (half_word)
    );

    // the incoming code decides which level opens a left half
    assign into_left = (wclk_src == left_is_high(fmt_sel));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (boundary && into_left) state_d = ST_LEFT;
            ST_LEFT:  if (boundary) state_d = into_left ? ST_LEFT : ST_RIGHT;
            ST_RIGHT: if (boundary) state_d = into_left ? ST_LEFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= 3'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE || (boundary && into_left))
                code_q <= fmt_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold_q <= '0;
            left_out    <= '0;
            right_out   <= '0;
            pair_valid  <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (boundary) begin
                if (state_q == ST_LEFT && !into_left)
                    left_hold_q <= half_word;
                if (state_q == ST_RIGHT && into_left) begin
                    left_out   <= left_hold_q;
                    right_out  <= half_word;
                    pair_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_rx_checks.sv
module pcm_rx_checks
    import pcm_rx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                pair_valid,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input half_state_t         state_q,
    input logic                gen_bclk,
    input logic                gen_left
);

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    assert_pair_after_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (state_q == ST_LEFT) && ($past(state_q) == ST_RIGHT));

    assert_wclk_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gen_left) |-> $fell(gen_bclk));

    assert_no_pair_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE) |-> !pair_valid);

endmodule

bind pcm_serial_rx pcm_rx_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (pair_valid),
    .left_out   (left_out),
    .right_out  (right_out),
    .state_q    (state_q),
    .gen_bclk   (gen_bclk),
    .gen_left   (gen_left)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
    localparam int HD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        bclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
    logic        bclk_out, wclk_out, clk_drive_en, pair_valid;
    logic [23:0] left_out, right_out;

    pcm_serial_rx #(.HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata_in(sdata_in),
        .bclk_out(bclk_out), .wclk_out(wclk_out), .clk_drive_en(clk_drive_en),
        .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
    );

    always #5 clk = ~clk;

    int          n_cmp = 0, n_bad = 0, wd = 0;
    bit          mon_en = 1'b0;
    string       cur_req = "R8";
    logic [23:0] exp_l[$], exp_r[$];
    logic [23:0] hold_l = '0, hold_r = '0;

    task automatic check(bit ok, string req, string what, logic [23:0] act, logic [23:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // per-cycle comparison against the model's queue of serialised pairs
    always @(negedge clk) begin
        if (mon_en) begin
            if (pair_valid) begin
                if (exp_l.size() == 0) begin
                    check(1'b0, cur_req, "unexpected pair", left_out, 24'h0);
                end else begin
                    logic [23:0] el, er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    check(left_out == el, cur_req, "left word", left_out, el);
                    check(right_out == er, cur_req, "right word", right_out, er);
                end
                hold_l = left_out;
                hold_r = right_out;
            end else begin
                check(left_out == hold_l && right_out == hold_r, "R6", "pair held",
                      left_out ^ right_out, hold_l ^ hold_r);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 180000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <180000 cycles", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int len_of(int c);
        case (c)
            0: return 16;
            1: return 18;
            2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic lvl_of(int c);
        return (c == 5 || c == 7) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [23:0] rand_val(int c);
        logic [23:0] m;
        m = 24'hFFFFFF >> (24 - len_of(c));
        return 24'($urandom) & m;
    endfunction

    function automatic logic [23:0] aligned(int c, logic [23:0] v);
        return v << (24 - len_of(c));
    endfunction

    // serial bit at position idx of a half with 'bits' clocks; padding alternates
    function automatic logic exp_bit(int c, logic [23:0] v, int idx, int bits);
        int n, first;
        logic pad;
        n   = len_of(c);
        pad = (idx % 2 == 0);
        if (c <= 3) begin
            first = bits - n;
            if (idx >= first) return v[n - 1 - (idx - first)];
        end else if (c == 4 || c == 6) begin
            if (idx < 24) return v[23 - idx];
        end else begin
            if (idx >= 1 && idx <= 24) return v[24 - idx];
        end
        return pad;
    endfunction

    task automatic do_reset(int c);
        mon_en = 1'b0;
        rst_n = 1'b0;
        fmt_sel = 3'(c);
        bclk_in = 1'b0; wclk_in = 1'b0; sdata_in = 1'b0;
        exp_l.delete(); exp_r.delete();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(left_out == 24'h0, "R8", "left after reset", left_out, 24'h0);
        check(right_out == 24'h0, "R8", "right after reset", right_out, 24'h0);
        check(pair_valid == 1'b0, "R8", "strobe after reset", 24'(pair_valid), 24'h0);
        check(clk_drive_en == (c >= 6), "R4", "clock drive enable", 24'(clk_drive_en), 24'(c >= 6));
        hold_l = '0; hold_r = '0;
        mon_en = 1'b1;
    endtask

    task automatic send_bit(logic w, logic d);
        bclk_in = 1'b0; wclk_in = w; sdata_in = d;
        repeat (2) @(negedge clk);
        bclk_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(int c, logic w, logic [23:0] v, int bits);
        for (int i = 0; i < bits; i++) send_bit(w, exp_bit(c, v, i, bits));
    endtask

    task automatic finish_run(string req);
        repeat (8) @(negedge clk);
        check(exp_l.size() == 0, req, "pairs still pending", 24'(exp_l.size()), 24'h0);
        mon_en = 1'b0;
    endtask

    task automatic run_slave(int c, int nfr, int bits, string req);
        logic lv;
        cur_req = req;
        do_reset(c);
        lv = lvl_of(c);
        send_half(c, ~lv, 24'h0, bits);
        for (int f = 0; f < nfr; f++) begin
            logic [23:0] a, b;
            a = rand_val(c); b = rand_val(c);
            exp_l.push_back(aligned(c, a)); exp_r.push_back(aligned(c, b));
            send_half(c, lv, a, bits);
            send_half(c, ~lv, b, bits);
        end
        send_half(c, lv, 24'h0, 4);
        finish_run(req);
    endtask

    // R7: code 0 -> 4 requested during a right half
    task automatic run_switch();
        cur_req = "R7";
        do_reset(0);
        send_half(0, 1'b0, 24'h0, 32);
        for (int f = 0; f < 3; f++) begin
            logic [23:0] a, b;
            a = rand_val(0); b = rand_val(0);
            exp_l.push_back(aligned(0, a)); exp_r.push_back(aligned(0, b));
            send_half(0, 1'b1, a, 32);
            for (int i = 0; i < 32; i++) begin
                if (f == 2 && i == 1) fmt_sel = 3'd4;
                send_bit(1'b0, exp_bit(0, b, i, 32));
            end
        end
        for (int f = 0; f < 2; f++) begin
            logic [23:0] a, b;
            a = rand_val(4); b = rand_val(4);
            exp_l.push_back(a); exp_r.push_back(b);
            send_half(4, 1'b1, a, 32);
            send_half(4, 1'b0, b, 32);
        end
        send_half(4, 1'b1, 24'h0, 4);
        finish_run("R7");
    endtask

    task automatic run_master(int c, int nfr, string req);
        logic lv, pb, pw;
        logic [23:0] a, b;
        int idx, fcnt, since;
        bit started, done;
        cur_req = req;
        do_reset(c);
        lv = lvl_of(c);
        pb = bclk_out; pw = wclk_out;
        idx = 0; fcnt = 0; since = 0; started = 0; done = 0;
        a = '0; b = '0;
        while (!done) begin
            @(negedge clk);
            since++;
            if (pb && !bclk_out) begin
                if (started)
                    check(since == 2 * HD, "R4", "bit clock period", 24'(since), 24'(2 * HD));
                since = 0;
                if (wclk_out != pw) begin
                    if (started) check(idx == 32, "R4", "bits per word clock level", 24'(idx), 24'd32);
                    idx = 0;
                    started = 1;
                    if (wclk_out == lv) begin
                        if (fcnt == nfr) begin
                            done = 1;
                        end else begin
                            a = rand_val(c); b = rand_val(c);
                            exp_l.push_back(a); exp_r.push_back(b);
                            fcnt++;
                        end
                    end
                end
                sdata_in = exp_bit(c, (wclk_out == lv) ? a : b, idx, 32);
                idx++;
            end
            pb = bclk_out;
            pw = wclk_out;
        end
        check(clk_drive_en == 1'b1, "R4", "clock drive enable in master", 24'(clk_drive_en), 24'h1);
        finish_run(req);
    endtask

    initial begin
        run_slave(0, 3, 16, "R1");
        run_slave(0, 3, 32, "R5");
        run_slave(1, 3, 18, "R1");
        run_slave(2, 3, 32, "R1");
        run_slave(3, 3, 24, "R1");
        run_slave(3, 3, 64, "R9");
        run_slave(4, 3, 24, "R2");
        run_slave(4, 3, 64, "R5");
        run_slave(5, 3, 25, "R3");
        run_slave(5, 3, 40, "R3");
        run_switch();
        run_master(6, 3, "R4");
        run_master(7, 3, "R4");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule